// File: doc/BRIEF.md
# GPIO Pin Interrupt Selector and Detector

This block sits between a wide bank of GPIO pins and an interrupt controller. It has a fixed number of interrupt channels. Each channel picks one pin by its index and watches that pin for a chosen trigger condition. When the condition is met, the channel records the event in a status bit and raises its own interrupt line. Every pin passes through a two-stage synchroniser before detection.

Software sets up the block through a plain 32-bit register port. A write strobe, a word address and write data change the registers on the clock edge. Read data is decoded from the address combinationally, so a read made in the cycle after a write already shows the new value. There are three kinds of register. Source-select words carry the pin index and enable of four channels each. Trigger words carry a 2-bit trigger code for sixteen channels each. One status word holds one bit per channel, and software clears a bit in it by writing zero to that bit.

Top module: `pin_irq_router`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: Source-select words sit at addresses 0 to 7. Channel n uses word n/4, byte lane n%4 (bits [(n%4)*8 +: 8]). In that lane, bits [6:0] hold the pin index and bit 7 is the channel enable. The words read back exactly as written.
- R3: Trigger words sit at addresses 8 and 9. Channel n uses word 8+n/16, bits [(n%16)*2 +: 2]. The codes are 0 for rising edge, 1 for falling edge, 2 for high level and 3 for low level.
- R4: In an edge mode, a matching transition on the selected pin sets the channel's status bit three clock edges after the pin changes. The bit stays set until software clears it. A transition in the other direction sets nothing.
- R5: In a level mode, the status bit follows whether the selected pin is at its active level, with the same three-edge latency.
- R6: The status word is at address 10, with bit n for channel n. Writing 0 to a bit clears it in an edge mode, and writing 1 leaves it unchanged. A read in the next cycle returns the cleared value.
- R7: In a level mode, a cleared status bit reads 1 again in the next cycle if the active level is still present.
- R8: If an event and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R9: Interrupt output n is high exactly when channel n is enabled and its status bit is 1. Disabling a channel masks its output but does not clear its status bit.
- R10: A disabled channel never sets its status bit, whatever its pin does.
- R11: Switching a channel from a level mode to an edge mode does not create an event on its own. Once software clears the status bit after the switch, the bit stays 0 while the pin holds steady.
- R12: Every pin index from 0 to 127 is reachable. When the pin count is set below the index range, an index at or above it selects a constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| gpio_in | input | NUM_PINS (128) | Asynchronous GPIO pin inputs |
| irq_out | output | NUM_CH (32) | Per-channel interrupt outputs |

## Verification
Some properties are checked on every cycle. An interrupt line must never be high for a disabled channel. A status bit may rise only after a detected event. An edge-mode status bit may fall only under a clearing write. A disabled channel in a level mode holds its status at zero. An event always beats a clear on the same edge. Other behaviour can only be shown by the bench's scenarios: the register layouts and trigger codes, the three-edge latency through the synchroniser, the level bit reasserting after a clear, the absence of a spurious event on a level-to-edge switch, and exact same-edge timing of a clear against an arriving edge.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   typedef enum logic [1:0] {
      TRIG_RISE = 2'd0,
      TRIG_FALL = 2'd1,
      TRIG_HIGH = 2'd2,
      TRIG_LOW  = 2'd3
   } trig_e;

   localparam int LANE_W      = 8;
   localparam int SEL_PER_REG = 4;
   localparam int TYP_PER_REG = 16;
   localparam int TYP_W       = 2;
   localparam int EN_BIT      = 7;

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int WIDTH  = 128,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] now_q,
   output logic [WIDTH-1:0] prev_q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         prev_q <= stg[STAGES-1];
      end
   end

   assign now_q = stg[STAGES-1];

endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int IDX_W  = 7,
   parameter int ADDR_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [31:0]                     wdata,
   input  logic [NUM_CH-1:0]               status,
   output logic [31:0]                     rdata,
   output logic [NUM_CH-1:0][IDX_W-1:0]    ch_idx,
   output logic [NUM_CH-1:0]               ch_en,
   output logic [NUM_CH-1:0][TYP_W-1:0]    ch_type,
   output logic [NUM_CH-1:0]               clr_mask
);

   localparam int SEL_REGS  = NUM_CH / SEL_PER_REG;
   localparam int TYP_REGS  = NUM_CH / TYP_PER_REG;
   localparam int TYP_BASE  = SEL_REGS;
   localparam int STAT_ADDR = SEL_REGS + TYP_REGS;

   logic [31:0] sel_q [SEL_REGS];
   logic [31:0] typ_q [TYP_REGS];
   logic        stat_hit;

   assign stat_hit = (addr == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SEL_REGS; i++) sel_q[i] <= '0;
         for (int j = 0; j < TYP_REGS; j++) typ_q[j] <= '0;
      end else if (we) begin
         for (int i = 0; i < SEL_REGS; i++)
            if (addr == ADDR_W'(i)) sel_q[i] <= wdata;
         for (int j = 0; j < TYP_REGS; j++)
            if (addr == ADDR_W'(TYP_BASE + j)) typ_q[j] <= wdata;
      end
   end

   // write-zero-to-clear: a 0 in the data clears, a 1 keeps
   assign clr_mask = (we && stat_hit) ? ~wdata[NUM_CH-1:0] : '0;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < SEL_REGS; i++)
         if (addr == ADDR_W'(i)) rdata = sel_q[i];
      for (int j = 0; j < TYP_REGS; j++)
         if (addr == ADDR_W'(TYP_BASE + j)) rdata = typ_q[j];
      if (stat_hit) rdata[NUM_CH-1:0] = status;
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_fields
      localparam int SR = n / SEL_PER_REG;
      localparam int SL = (n % SEL_PER_REG) * LANE_W;
      localparam int TR = n / TYP_PER_REG;
      localparam int TL = (n % TYP_PER_REG) * TYP_W;
      assign ch_idx[n]  = sel_q[SR][SL +: IDX_W];
      assign ch_en[n]   = sel_q[SR][SL + EN_BIT];
      assign ch_type[n] = typ_q[TR][TL +: TYP_W];
   end

endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
   import pirq_pkg::*;
#(
   parameter int NUM_CH   = 32,
   parameter int NUM_PINS = 128,
   parameter int IDX_W    = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PINS-1:0]           pin_now,
   input  logic [NUM_PINS-1:0]           pin_prev,
   input  logic [NUM_CH-1:0][IDX_W-1:0]  ch_idx,
   input  logic [NUM_CH-1:0]             ch_en,
   input  logic [NUM_CH-1:0][TYP_W-1:0]  ch_type,
   input  logic [NUM_CH-1:0]             clr_mask,
   output logic [NUM_CH-1:0]             status,
   output logic [NUM_CH-1:0]             set_vec,
   output logic [NUM_CH-1:0]             edge_mode,
   output logic [NUM_CH-1:0]             irq_out
);

   localparam bit FULL_RANGE = (NUM_PINS == (1 << IDX_W));

   logic [NUM_CH-1:0] stat_d;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic cur;
      logic prv;
      logic hit;

      if (FULL_RANGE) begin : g_direct
         assign cur = pin_now[ch_idx[n]];
         assign prv = pin_prev[ch_idx[n]];
      end else begin : g_guarded
         logic in_range;
         assign in_range = (ch_idx[n] < IDX_W'(NUM_PINS));
         assign cur = in_range ? pin_now[ch_idx[n]]  : 1'b0;
         assign prv = in_range ? pin_prev[ch_idx[n]] : 1'b0;
      end

      always_comb begin
         unique case (trig_e'(ch_type[n]))
            TRIG_RISE: hit = cur & ~prv;
            TRIG_FALL: hit = ~cur & prv;
            TRIG_HIGH: hit = cur;
            TRIG_LOW:  hit = ~cur;
            default:   hit = 1'b0;
         endcase
      end

      assign set_vec[n]   = ch_en[n] & hit;
      assign edge_mode[n] = ~ch_type[n][1];
      // edge: sticky with set beating clear; level: track active level
      assign stat_d[n]    = edge_mode[n] ? ((status[n] & ~clr_mask[n]) | set_vec[n])
                                         : set_vec[n];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= stat_d;
   end

   assign irq_out = status & ch_en;

endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
   import pirq_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int NUM_PINS    = 128,
   parameter int IDX_W       = 7,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] gpio_in,
   output logic [NUM_CH-1:0]   irq_out
);

   localparam int NUM_REGS = NUM_CH / SEL_PER_REG + NUM_CH / TYP_PER_REG + 1;

   if (NUM_CH % TYP_PER_REG != 0 || NUM_CH > 32 || NUM_CH < TYP_PER_REG) begin : g_bad_ch
      $error("pin_irq_router: NUM_CH must be 16 or 32");
   end
   if (IDX_W < 1 || IDX_W > EN_BIT) begin : g_bad_idx
      $error("pin_irq_router: IDX_W must fit below the enable bit");
   end
   if (NUM_PINS < 1 || NUM_PINS > (1 << IDX_W)) begin : g_bad_pins
      $error("pin_irq_router: NUM_PINS must be reachable by the index");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("pin_irq_router: ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0]          pin_now;
   logic [NUM_PINS-1:0]          pin_prev;
   logic [NUM_CH-1:0][IDX_W-1:0] ch_idx;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0][TYP_W-1:0] ch_type;
   logic [NUM_CH-1:0]            clr_mask;
   logic [NUM_CH-1:0]            status;
   logic [NUM_CH-1:0]            set_vec;
   logic [NUM_CH-1:0]            edge_mode;

   pirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (gpio_in),
      .now_q  (pin_now),
      .prev_q (pin_prev)
   );

   pirq_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .status   (status),
      .rdata    (reg_rdata),
      .ch_idx   (ch_idx),
      .ch_en    (ch_en),
      .ch_type  (ch_type),
      .clr_mask (clr_mask)
   );

   pirq_detect #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_now   (pin_now),
      .pin_prev  (pin_prev),
      .ch_idx    (ch_idx),
      .ch_en     (ch_en),
      .ch_type   (ch_type),
      .clr_mask  (clr_mask),
      .status    (status),
      .set_vec   (set_vec),
      .edge_mode (edge_mode),
      .irq_out   (irq_out)
   );

endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
   parameter int NUM_CH    = 32,
   parameter int ADDR_W    = 4,
   parameter int STAT_ADDR = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [NUM_CH-1:0] status,
   input logic [NUM_CH-1:0] set_vec,
   input logic [NUM_CH-1:0] edge_mode,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] irq_out
);

   logic [NUM_CH-1:0] wr_zero;
   assign wr_zero = (we && addr == ADDR_W'(STAT_ADDR)) ? ~wdata[NUM_CH-1:0] : '0;

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~ch_en) == '0);

   // R4
   no_unprompted_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & ~$past(set_vec)) == '0);

   // R6
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~status & $past(status & edge_mode & ~wr_zero)) == '0);

   // R10
   level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(~edge_mode & ~ch_en) & status) == '0);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(set_vec) & ~status) == '0);

endmodule

bind pin_irq_router pirq_chk #(
   .NUM_CH    (NUM_CH),
   .ADDR_W    (ADDR_W),
   .STAT_ADDR (NUM_CH / 4 + NUM_CH / 16)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we        (reg_we),
   .addr      (reg_addr),
   .wdata     (reg_wdata),
   .status    (status),
   .set_vec   (set_vec),
   .edge_mode (edge_mode),
   .ch_en     (ch_en),
   .irq_out   (irq_out)
);

// File: tb/sim_pin_irq_router.sv
`timescale 1ns/1ps
module sim_pin_irq_router;

   localparam int NCH  = 32;
   localparam int NPIN = 128;
   localparam int STAT = 10;

   logic            clk;
   logic            rst_n;
   logic            reg_we;
   logic [3:0]      reg_addr;
   logic [31:0]     reg_wdata;
   logic [31:0]     reg_rdata;
   logic [NPIN-1:0] gpio_in;
   logic [NCH-1:0]  irq_out;

   int n_chk  = 0;
   int n_fail = 0;

   pin_irq_router u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .gpio_in   (gpio_in),
      .irq_out   (irq_out)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // fields: ch[16:12] pin[11:5] type[4:3] start[2] end[1] expect[0]
   localparam logic [16:0] VEC [8] = '{
      {5'd0,  7'd5,   2'd0, 1'b0, 1'b1, 1'b1},
      {5'd1,  7'd6,   2'd0, 1'b1, 1'b0, 1'b0},
      {5'd2,  7'd7,   2'd1, 1'b1, 1'b0, 1'b1},
      {5'd3,  7'd8,   2'd1, 1'b0, 1'b1, 1'b0},
      {5'd17, 7'd100, 2'd2, 1'b0, 1'b1, 1'b1},
      {5'd18, 7'd101, 2'd2, 1'b1, 1'b0, 1'b0},
      {5'd31, 7'd127, 2'd3, 1'b1, 1'b0, 1'b1},
      {5'd30, 7'd0,   2'd3, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 4'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input int ch, input int pin, input bit en, input int typ);
      logic [31:0] v;
      rd(ch / 4, v);
      v[(ch % 4) * 8 +: 8] = {en, 7'(pin)};
      wr(ch / 4, v);
      rd(8 + ch / 16, v);
      v[(ch % 16) * 2 +: 2] = 2'(typ);
      wr(8 + ch / 16, v);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int ch, pin, typ;
      bit s, e, x;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; gpio_in = '0;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1: everything zero after reset
      for (int a = 0; a <= STAT; a++) begin
         rd(a, d);
         chk("R1 reg", d, 32'h0);
      end
      chk("R1 irq", irq_out, 32'h0);

      // table: R4 edges, R5 levels, R12 top pin index
      for (int i = 0; i < 8; i++) begin
         ch = int'(VEC[i][16:12]); pin = int'(VEC[i][11:5]); typ = int'(VEC[i][4:3]);
         s = VEC[i][2]; e = VEC[i][1]; x = VEC[i][0];
         gpio_in = '0;
         cfg(ch, pin, 1'b1, typ);
         gpio_in[pin] = s;
         idle(5);
         wr(STAT, ~(32'h1 << ch));
         gpio_in[pin] = e;
         idle(5);
         rd(STAT, d);
         chk(typ < 2 ? "R4 edge status" : "R5 level status", 32'(d[ch]), 32'(x));
         chk("R9 R12 irq per vector", 32'(irq_out[ch]), 32'(x));
      end

      // R2 / R3: register layout readback
      rd(0, d);  chk("R2 select lanes", d, 32'h88878685);
      rd(8, d);  chk("R3 type word 0", d, 32'h00000050);
      rd(9, d);  chk("R3 type word 1", d, 32'hF0000028);

      // R9: disabling masks irq but keeps status (ch0 still set)
      gpio_in = '0;
      cfg(0, 5, 1'b0, 0);
      idle(1);
      rd(STAT, d);
      chk("R9 status kept", 32'(d[0]), 32'h1);
      chk("R9 irq masked", 32'(irq_out[0]), 32'h0);

      // R10: disabled channel ignores an edge
      wr(STAT, ~32'h1);
      gpio_in[5] = 1'b1;
      idle(5);
      rd(STAT, d);
      chk("R10 no set when disabled", 32'(d[0]), 32'h0);

      // R6: write 1 keeps, write 0 clears, next read sees it
      cfg(0, 5, 1'b1, 0);
      gpio_in[5] = 1'b0; idle(2); gpio_in[5] = 1'b1; idle(5);
      wr(STAT, 32'hFFFF_FFFF);
      rd(STAT, d);
      chk("R6 write one keeps", 32'(d[0]), 32'h1);
      wr(STAT, ~32'h1);
      rd(STAT, d);
      chk("R6 write zero clears", 32'(d[0]), 32'h0);

      // R7: level still present returns at once
      gpio_in[100] = 1'b1;
      idle(5);
      wr(STAT, ~(32'h1 << 17));
      rd(STAT, d);
      chk("R7 level returns", 32'(d[17]), 32'h1);

      // R11: level -> rising edge with pin steady high, no spurious set
      cfg(17, 100, 1'b1, 0);
      wr(STAT, ~(32'h1 << 17));
      idle(5);
      rd(STAT, d);
      chk("R11 no spurious edge", 32'(d[17]), 32'h0);

      // R8: clear and rising edge land on the same clock edge (ch1, pin6)
      gpio_in[6] = 1'b0;
      idle(5);
      wr(STAT, ~32'h2);
      @(negedge clk);
      gpio_in[6] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(STAT); reg_wdata = ~32'h2;
      @(negedge clk);
      reg_we = 1'b0;
      rd(STAT, d);
      chk("R8 set beats clear", 32'(d[1]), 32'h1);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule